// File: doc/BRIEF.md
# Hybrid Radix-4/Radix-8 Booth Signed Multiplier

This block multiplies two signed two's-complement operands and returns their full double-width product in the same cycle. It has no clock and no storage. It first scans the multiplier operand. When every radix-8 Booth digit of that operand falls within {0, ±1, ±2, ±4}, the block forms one partial product for each 3-bit step, which gives the smaller radix-8 digit count. If any radix-8 digit would need the awkward ±3 multiple, the block switches that whole operation to radix-4 Booth digits. Those digits only need {0, ±1, ±2}.

The block never builds a three-times multiple of the multiplicand, so its longest path never has an extra carry-propagate stage. A flag output reports which radix formed the product. Surrounding logic can use it for power or activity statistics, or ignore it.

Top module: `hybrid_booth_mul`

## Requirements
- R1: `product` equals the exact signed product of `multiplicand` and `multiplier`, interpreted as 16-bit two's complement, for every input pair and in both modes.
- R2: `mode_r8` is 1 exactly when none of the six radix-8 windows holds a ±3 digit, and 0 otherwise. The multiplier is sign-extended to 18 bits and a 0 is placed below bit 0. Window k covers bits [3k+2 : 3k-1], its value is -4·b3 + 2·b2 + b1 + b0, and the four window codes 0101, 0110, 1001 and 1010 give a ±3 digit.
- R3: A zero multiplier gives `mode_r8` = 1 and `product` = 0 for any multiplicand.
- R4: A multiplier whose three low bits are 011 or 101 forces radix-4 mode (`mode_r8` = 0), because its lowest window is 0110 or 1010.
- R5: A ±3 digit in the second-highest window alone, for example multiplier 16'h2800 (bits 14..11 = 0101), forces `mode_r8` = 0, and `product` stays exact.
- R6: Extreme operands (16'h8000, 16'h7FFF, 16'hFFFF, 0) give exact products in either mode, including 16'h8000 × 16'h8000 = 32'h4000_0000.
- R7: `mode_r8` depends only on `multiplier`. Changing `multiplicand` while `multiplier` is held leaves `mode_r8` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| multiplicand | input | 16 | Signed operand that is scaled by each Booth digit |
| multiplier | input | 16 | Signed operand that is recoded into Booth digits |
| product | output | 32 | Signed double-width product |
| mode_r8 | output | 1 | 1 when radix-8 digits formed the product, 0 when the radix-4 fallback was used |

## Verification
The bound checker tests product exactness against a wide signed multiply whenever the inputs change. On the same basis it tests that a zero multiplier gives radix-8 mode and a zero result, that a zero multiplicand zeroes the product, and that low multiplier bits 011 or 101 force the fallback. The full mode-flag rule over all six windows, the second-highest-window case, and the independence of the flag from the multiplicand are shown only by the bench's scenarios. The bench compares those scenarios with an arithmetic digit evaluation in the bench, over directed corners and seeded random operands split between both modes.

// File: rtl/hbm_pkg.sv
package hbm_pkg;

    // Magnitude of a Booth digit; the x3 multiple is deliberately absent.
    typedef enum logic [1:0] {
        MAG_ZERO = 2'd0,
        MAG_ONE  = 2'd1,
        MAG_TWO  = 2'd2,
        MAG_FOUR = 2'd3
    } mag_e;

    typedef struct packed {
        logic neg;
        mag_e mag;
    } digit_t;

    // Radix-4 digit from an overlapping 3-bit window {hi, mid, lo}.
    function automatic digit_t recode_r4(input logic [2:0] win);
        digit_t d;
        d.neg = 1'b0;
        d.mag = MAG_ZERO;
        unique case (win)
            3'b000, 3'b111: d.mag = MAG_ZERO;
            3'b001, 3'b010: d.mag = MAG_ONE;
            3'b011:         d.mag = MAG_TWO;
            3'b100: begin d.mag = MAG_TWO; d.neg = 1'b1; end
            3'b101, 3'b110: begin d.mag = MAG_ONE; d.neg = 1'b1; end
            default:        d.mag = MAG_ZERO;
        endcase
        return d;
    endfunction

    // Radix-8 digit from an overlapping 4-bit window. The four +-3 codes map to
    // zero here; the mode detector guarantees they are never selected.
    function automatic digit_t recode_r8(input logic [3:0] win);
        digit_t d;
        d.neg = 1'b0;
        d.mag = MAG_ZERO;
        unique case (win)
            4'b0000, 4'b1111: d.mag = MAG_ZERO;
            4'b0001, 4'b0010: d.mag = MAG_ONE;
            4'b0011, 4'b0100: d.mag = MAG_TWO;
            4'b0111:          d.mag = MAG_FOUR;
            4'b1000: begin d.mag = MAG_FOUR; d.neg = 1'b1; end
            4'b1011, 4'b1100: begin d.mag = MAG_TWO; d.neg = 1'b1; end
            4'b1101, 4'b1110: begin d.mag = MAG_ONE; d.neg = 1'b1; end
            default:          d.mag = MAG_ZERO;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/hbm_mode_detect.sv
module hbm_mode_detect #(
    parameter int W = 16
) (
    input  logic [W-1:0] mult,
    output logic         use_r8
);
    localparam int NDIG8 = (W + 2) / 3;
    localparam int EXT   = 3 * NDIG8;

    logic [EXT:0]       ext;
    logic [NDIG8-1:0]   hit;

    assign ext = {{(EXT - W + 1){mult[W-1]}}, mult[W-2:0], 1'b0};

    // One comparator per window; any match means a +-3 digit would be needed.
    for (genvar k = 0; k < NDIG8; k++) begin : g_win
        logic [3:0] win;
        assign win = ext[3*k+3 : 3*k];
        always_comb begin
            unique case (win)
                4'b0101, 4'b0110, 4'b1001, 4'b1010: hit[k] = 1'b1;
                default:                            hit[k] = 1'b0;
            endcase
        end
    end

    assign use_r8 = ~|hit;
endmodule

// File: rtl/hbm_digit_sel.sv
module hbm_digit_sel
    import hbm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                   use_r8,
    input  logic [W-1:0]           mult,
    output digit_t [W/2-1:0]       digits
);
    localparam int NDIG4 = W / 2;
    localparam int NDIG8 = (W + 2) / 3;
    localparam int EXT   = 3 * NDIG8;

    logic [EXT:0] ext;
    assign ext = {{(EXT - W + 1){mult[W-1]}}, mult[W-2:0], 1'b0};

    // Slot k carries radix-4 digit k, or radix-8 digit k when that exists.
    for (genvar k = 0; k < NDIG4; k++) begin : g_slot
        digit_t d4;
        assign d4 = recode_r4(ext[2*k+2 : 2*k]);
        if (k < NDIG8) begin : g_both
            digit_t d8;
            assign d8 = recode_r8(ext[3*k+3 : 3*k]);
            assign digits[k] = use_r8 ? d8 : d4;
        end else begin : g_r4_only
            assign digits[k] = use_r8 ? '{neg: 1'b0, mag: MAG_ZERO} : d4;
        end
    end
endmodule

// File: rtl/hbm_pp_sum.sv
module hbm_pp_sum
    import hbm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]        mcand,
    input  logic                use_r8,
    input  digit_t [W/2-1:0]    digits,
    output logic [2*W-1:0]      sum
);
    localparam int NDIG4 = W / 2;
    localparam int PW    = 2 * W;

    logic signed [PW-1:0] base;
    assign base = {{W{mcand[W-1]}}, mcand};

    logic [PW-1:0] pp [NDIG4];

    for (genvar k = 0; k < NDIG4; k++) begin : g_pp
        logic signed [PW-1:0] scaled;
        always_comb begin
            unique case (digits[k].mag)
                MAG_ZERO: scaled = '0;
                MAG_ONE:  scaled = base;
                MAG_TWO:  scaled = base <<< 1;
                MAG_FOUR: scaled = base <<< 2;
                default:  scaled = '0;
            endcase
            if (digits[k].neg)
                scaled = -scaled;
            pp[k] = use_r8 ? (scaled << (3 * k)) : (scaled << (2 * k));
        end
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < NDIG4; k++)
            sum = sum + pp[k];
    end
endmodule

// File: rtl/hybrid_booth_mul.sv
module hybrid_booth_mul
    import hbm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]   multiplicand,
    input  logic [W-1:0]   multiplier,
    output logic [2*W-1:0] product,
    output logic           mode_r8
);
    localparam int NDIG4 = W / 2;

    logic               use_r8;
    digit_t [NDIG4-1:0] digits;

    hbm_mode_detect #(.W(W)) u_detect (
        .mult   (multiplier),
        .use_r8 (use_r8)
    );

    hbm_digit_sel #(.W(W)) u_digits (
        .use_r8 (use_r8),
        .mult   (multiplier),
        .digits (digits)
    );

    hbm_pp_sum #(.W(W)) u_sum (
        .mcand  (multiplicand),
        .use_r8 (use_r8),
        .digits (digits),
        .sum    (product)
    );

    assign mode_r8 = use_r8;
endmodule

// File: rtl/hbm_checker.sv
module hbm_checker #(
    parameter int W = 16
) (
    input logic [W-1:0]   multiplicand,
    input logic [W-1:0]   multiplier,
    input logic [2*W-1:0] product,
    input logic           mode_r8
);
    logic signed [2*W-1:0] wide_a;
    logic signed [2*W-1:0] wide_b;
    logic signed [2*W-1:0] ref_p;

    assign wide_a = {{W{multiplicand[W-1]}}, multiplicand};
    assign wide_b = {{W{multiplier[W-1]}}, multiplier};
    assign ref_p  = wide_a * wide_b;

    always_comb begin
        p_exact_product_r1: assert (product == ref_p)
            else $error("product mismatch");
        p_zero_mult_r3: assert (!(multiplier == '0) || (mode_r8 && product == '0))
            else $error("zero multiplier case");
        p_low3b_fallback_r4: assert (!(multiplier[2:0] == 3'b011 || multiplier[2:0] == 3'b101) || !mode_r8)
            else $error("low window needs fallback");
        p_zero_mcand_r6: assert (!(multiplicand == '0) || product == '0)
            else $error("zero multiplicand case");
    end
endmodule

bind hybrid_booth_mul hbm_checker #(.W(W)) u_hbm_checker (
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product),
    .mode_r8      (mode_r8)
);

// File: tb/test_hybrid_booth_mul.sv
module test_hybrid_booth_mul;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic [W-1:0]   a, b;
    logic [2*W-1:0] p;
    logic           m8;
    int             n_checks = 0;
    int             n_fails  = 0;
    int             n_r8 = 0;
    int             n_r4 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hybrid_booth_mul #(.W(W)) i_hybrid_booth_mul (
        .multiplicand (a),
        .multiplier   (b),
        .product      (p),
        .mode_r8      (m8)
    );

    function automatic logic [2*W-1:0] exp_prod(input logic [W-1:0] x, input logic [W-1:0] y);
        longint sx, sy;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        return 32'(sx * sy);
    endfunction

    // Arithmetic evaluation of every radix-8 digit value.
    function automatic logic exp_mode(input logic [W-1:0] y);
        logic [18:0] e;
        int d;
        e = {y[15], y[15], y, 1'b0};
        for (int k = 0; k < 6; k++) begin
            d = -4 * int'(e[3*k+3]) + 2 * int'(e[3*k+2]) + int'(e[3*k+1]) + int'(e[3*k]);
            if (d == 3 || d == -3)
                return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", tag, a, b, act, expv);
        end
    endtask

    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
        @(posedge clk);
        a = x;
        b = y;
        @(negedge clk);
        check({tag, " R1 product"}, 64'(p), 64'(exp_prod(x, y)));
        check({tag, " R2 mode"}, 64'(m8), 64'(exp_mode(y)));
        if (m8) n_r8++; else n_r4++;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [W-1:0] x, y;
        logic first_mode;
        void'($urandom(32'h5eed_1234));
        a = '0;
        b = '0;

        // Idle state with zero operands (R3)
        @(negedge clk);
        check("R3 idle product", 64'(p), 64'd0);
        check("R3 idle mode", 64'(m8), 64'd1);

        // R3: zero multiplier with assorted multiplicands
        apply(16'h1234, 16'h0000, "R3");
        apply(16'h8000, 16'h0000, "R3");
        check("R3 mode zero multiplier", 64'(m8), 64'd1);

        // R4: low bits 011 / 101 force radix-4
        apply(16'h0005, 16'h0003, "R4");
        check("R4 low 011", 64'(m8), 64'd0);
        apply(16'hFF9C, 16'h7FF5, "R4");
        check("R4 low 101", 64'(m8), 64'd0);

        // R5: only the second-highest window needs +-3
        apply(16'h1357, 16'h2800, "R5");
        check("R5 upper window fallback", 64'(m8), 64'd0);
        apply(16'hABCD, 16'h0800, "R5 r8 neighbour");
        check("R5 neighbour stays r8", 64'(m8), 64'd1);

        // R6: extreme operands
        apply(16'h8000, 16'h8000, "R6");
        check("R6 min*min", 64'(p), 64'h4000_0000);
        apply(16'h7FFF, 16'h7FFF, "R6");
        apply(16'h7FFF, 16'h8000, "R6");
        apply(16'hFFFF, 16'hFFFF, "R6");
        apply(16'h0000, 16'h7FFF, "R6");
        apply(16'h8000, 16'hFFFF, "R6");

        // R7: mode independent of multiplicand
        for (int i = 0; i < 40; i++) begin
            y = 16'($urandom);
            apply(16'($urandom), y, "R7");
            first_mode = m8;
            apply(16'($urandom), y, "R7");
            check("R7 mode unchanged", 64'(m8), 64'(first_mode));
        end

        // R1/R2: random operands
        for (int i = 0; i < 3000; i++)
            apply(16'($urandom), 16'($urandom), "R1 random");

        // R1/R2: operands drawn to land in radix-8 mode
        for (int i = 0; i < 500; i++) begin
            y = 16'($urandom);
            for (int t = 0; t < 64 && !exp_mode(y); t++)
                y = 16'($urandom);
            x = 16'($urandom);
            apply(x, y, "R1 forced r8");
        end

        // Both modes must have been reached (R2)
        check("R2 r8 reached", 64'(n_r8 > 0), 64'd1);
        check("R2 r4 reached", 64'(n_r4 > 0), 64'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule